// File: doc/BRIEF.md
# Product-Term Logic Array with Shared Expander Terms

This block is the combinational core of one logic-array block: sixteen macrocells that each build a sum of products from a common set of array inputs. Every macrocell owns five product terms. Each term is an AND over literals that configuration picks from the array inputs, and a per-term enable decides whether the term joins the macrocell's OR.

Each macrocell also owns a sixth, separate term that it gives to a shared pool. That term sees only the external array inputs, and its output is inverted before it goes back into the array. Any macrocell can use any pool output in two ways. It can AND the output into one of its own product terms, or it can OR the output straight into its sum. Several macrocells can read the same pool output at once. Routing through the pool adds delay in silicon, so the block reports for each macrocell whether its sum depends on a pool output.

The block is configured through flat mask vectors and updates its outputs in the same cycle as its inputs. It holds no state.

Top module: `pta_array`

## Requirements
- R1: Each array input has a 2-bit literal code in every term, placed at bits [2*i+1:2*i] of that term's literal slice. Code 00 ignores the input, 01 requires it to be 1, 10 requires it to be 0, and 11 forces the term to 0. The term is the AND of all literal conditions.
- R2: A product term that selects no literal and no pool output evaluates to 1.
- R3: `sum_o[m]` is the OR of the product terms of macrocell m whose enable bit `pt_en_i[m*N_PT+p]` is 1. A term whose enable bit is 0 contributes nothing. A macrocell with no enabled term and no direct pool selection outputs 0.
- R4: `pool_o[m]` is the inverse of the AND of the pool-term literals of macrocell m. Those literals sit at slice `pool_lit_i[m*2*N_IN +: 2*N_IN]` and use the R1 codes. A pool term with no literals gives 0.
- R5: Product term p of macrocell m ANDs in pool output e when `pt_pool_i[(m*N_PT+p)*N_MC+e]` is 1. Its literal slice is `pt_lit_i[(m*N_PT+p)*2*N_IN +: 2*N_IN]`.
- R6: Macrocell m ORs pool output e straight into its sum when `sum_pool_i[m*N_MC+e]` is 1.
- R7: One pool output can feed any number of macrocells at the same time.
- R8: Pool outputs depend only on `arr_i` and `pool_lit_i`. Product-term literals, enables and pool selections leave `pool_o` unchanged.
- R9: `slow_o[m]` is 1 exactly when macrocell m selects a pool output, either directly into its sum or through a product term whose enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_i | input | N_IN | Array input signals |
| pt_lit_i | input | N_MC*N_PT*2*N_IN | Literal codes for every product term |
| pt_pool_i | input | N_MC*N_PT*N_MC | Pool outputs ANDed into each product term |
| pt_en_i | input | N_MC*N_PT | Product-term enables for the OR |
| pool_lit_i | input | N_MC*2*N_IN | Literal codes for each donated pool term |
| sum_pool_i | input | N_MC*N_MC | Pool outputs ORed straight into each sum |
| sum_o | output | N_MC | Macrocell sums |
| pool_o | output | N_MC | Inverted pool-term outputs |
| slow_o | output | N_MC | Sum depends on a pool output (longer path) |

## Verification
The bench builds the block with its default parameters: 8 array inputs, 16 macrocells and 5 terms per macrocell. With these values every literal code can be reached on every input, and every macrocell can pick any of the sixteen pool outputs. A table of single-term cases covers each literal code, including the all-true, all-complement and empty masks. Directed cases then share one pool output across several macrocells, use pool outputs both inside terms and directly in sums, and toggle enables to observe the slow indicator. Random sparse masks are checked against a software sum-of-products model on all three outputs.

// File: rtl/pta_pkg.sv
package pta_pkg;

    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;

    typedef struct packed {
        logic sum;
        logic slow;
    } mc_out_t;

    function automatic logic lit_ok(lit_e code, logic x);
        case (code)
            LIT_OFF:  return 1'b1;
            LIT_POS:  return x;
            LIT_NEG:  return ~x;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pta_pterm.sv
module pta_pterm
    import pta_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_EXP = 16
) (
    input  logic [N_IN-1:0]   arr_i,
    input  logic [2*N_IN-1:0] lit_i,
    input  logic [N_EXP-1:0]  exp_i,
    input  logic [N_EXP-1:0]  sel_i,
    output logic              term_o
);

    logic lit_and;
    logic has_kill;
    logic is_empty;

    always_comb begin
        lit_and = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            lit_and = lit_and & lit_ok(lit_e'(lit_i[2*i +: 2]), arr_i[i]);
        end
        term_o = lit_and & (&(exp_i | ~sel_i));
    end

    always_comb begin
        has_kill = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            has_kill = has_kill | (lit_i[2*i +: 2] == 2'b11);
        end
        is_empty = (lit_i == '0) && (sel_i == '0);
    end

    always_comb begin
        if (!$isunknown({arr_i, lit_i, exp_i, sel_i, term_o})) begin
            if (has_kill) begin
                p_kill_zero_r1: assert (term_o == 1'b0);
            end
            if (is_empty) begin
                p_empty_one_r2: assert (term_o == 1'b1);
            end
        end
    end

endmodule

// File: rtl/pta_pool.sv
module pta_pool #(
    parameter int N_IN = 8,
    parameter int N_MC = 16
) (
    input  logic [N_IN-1:0]        arr_i,
    input  logic [N_MC*2*N_IN-1:0] lit_i,
    output logic [N_MC-1:0]        pool_o
);

    localparam int LIT_W = 2 * N_IN;

    logic [N_MC-1:0] raw;

    for (genvar m = 0; m < N_MC; m++) begin : g_donor
        pta_pterm #(.N_IN(N_IN), .N_EXP(1)) u_term (
            .arr_i  (arr_i),
            .lit_i  (lit_i[m*LIT_W +: LIT_W]),
            .exp_i  (1'b0),
            .sel_i  (1'b0),
            .term_o (raw[m])
        );
    end

    assign pool_o = ~raw;

    always_comb begin
        if (!$isunknown({arr_i, lit_i, pool_o})) begin
            for (int m = 0; m < N_MC; m++) begin
                if (lit_i[m*LIT_W +: LIT_W] == '0) begin
                    p_empty_pool_low_r4: assert (pool_o[m] == 1'b0);
                end
            end
        end
    end

endmodule

// File: rtl/pta_macrocell.sv
module pta_macrocell
    import pta_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int N_MC = 16,
    parameter int N_PT = 5
) (
    input  logic [N_IN-1:0]        arr_i,
    input  logic [N_PT*2*N_IN-1:0] lit_i,
    input  logic [N_PT*N_MC-1:0]   psel_i,
    input  logic [N_PT-1:0]        en_i,
    input  logic [N_MC-1:0]        ssel_i,
    input  logic [N_MC-1:0]        pool_i,
    output mc_out_t                out_o
);

    localparam int LIT_W = 2 * N_IN;

    logic [N_PT-1:0] pt;
    logic [N_PT-1:0] pt_uses_pool;

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        pta_pterm #(.N_IN(N_IN), .N_EXP(N_MC)) u_pt (
            .arr_i  (arr_i),
            .lit_i  (lit_i[p*LIT_W +: LIT_W]),
            .exp_i  (pool_i),
            .sel_i  (psel_i[p*N_MC +: N_MC]),
            .term_o (pt[p])
        );
        assign pt_uses_pool[p] = en_i[p] & (|psel_i[p*N_MC +: N_MC]);
    end

    always_comb begin
        out_o.sum  = (|(pt & en_i)) | (|(pool_i & ssel_i));
        out_o.slow = (|pt_uses_pool) | (|ssel_i);
    end

    always_comb begin
        if (!$isunknown({arr_i, lit_i, psel_i, en_i, ssel_i, pool_i, out_o})) begin
            if ((en_i == '0) && (ssel_i == '0)) begin
                p_idle_sum_low_r3: assert (out_o.sum == 1'b0);
            end
            if ((pool_i & ssel_i) != '0) begin
                p_direct_pool_sets_sum_r6: assert (out_o.sum == 1'b1);
            end
            if ((ssel_i == '0) && (psel_i == '0)) begin
                p_no_pool_fast_r9: assert (out_o.slow == 1'b0);
            end
        end
    end

endmodule

// File: rtl/pta_array.sv
module pta_array
    import pta_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int N_MC = 16,
    parameter int N_PT = 5
) (
    input  logic [N_IN-1:0]             arr_i,
    input  logic [N_MC*N_PT*2*N_IN-1:0] pt_lit_i,
    input  logic [N_MC*N_PT*N_MC-1:0]   pt_pool_i,
    input  logic [N_MC*N_PT-1:0]        pt_en_i,
    input  logic [N_MC*2*N_IN-1:0]      pool_lit_i,
    input  logic [N_MC*N_MC-1:0]        sum_pool_i,
    output logic [N_MC-1:0]             sum_o,
    output logic [N_MC-1:0]             pool_o,
    output logic [N_MC-1:0]             slow_o
);

    localparam int LIT_W   = 2 * N_IN;
    localparam int MC_LIT  = N_PT * LIT_W;
    localparam int MC_PSEL = N_PT * N_MC;

    logic [N_MC-1:0] pool;
    mc_out_t         mc_out [N_MC];

    pta_pool #(.N_IN(N_IN), .N_MC(N_MC)) u_pool (
        .arr_i  (arr_i),
        .lit_i  (pool_lit_i),
        .pool_o (pool)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        pta_macrocell #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u_mc (
            .arr_i  (arr_i),
            .lit_i  (pt_lit_i[m*MC_LIT +: MC_LIT]),
            .psel_i (pt_pool_i[m*MC_PSEL +: MC_PSEL]),
            .en_i   (pt_en_i[m*N_PT +: N_PT]),
            .ssel_i (sum_pool_i[m*N_MC +: N_MC]),
            .pool_i (pool),
            .out_o  (mc_out[m])
        );
        assign sum_o[m]  = mc_out[m].sum;
        assign slow_o[m] = mc_out[m].slow;
    end

    assign pool_o = pool;

endmodule

// File: tb/pta_array_test.sv
module pta_array_test;

    localparam int NI = 8;
    localparam int NM = 16;
    localparam int NP = 5;
    localparam int LW = 2 * NI;

    // {arr, literal slice of macrocell 0 term 0, expected sum_o[0]}
    localparam logic [24:0] TBL [12] = '{
        {8'h01, 16'h0001, 1'b1},
        {8'h00, 16'h0001, 1'b0},
        {8'h00, 16'h0002, 1'b1},
        {8'h01, 16'h0002, 1'b0},
        {8'h01, 16'h0003, 1'b0},
        {8'hFF, 16'h5555, 1'b1},
        {8'hFE, 16'h5555, 1'b0},
        {8'h00, 16'hAAAA, 1'b1},
        {8'h00, 16'h0000, 1'b1},
        {8'h03, 16'h0009, 1'b0},
        {8'h01, 16'h0009, 1'b1},
        {8'h80, 16'h4000, 1'b1}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [NI-1:0]       arr      = '0;
    logic [NM*NP*LW-1:0] pt_lit   = '0;
    logic [NM*NP*NM-1:0] pt_pool  = '0;
    logic [NM*NP-1:0]    pt_en    = '0;
    logic [NM*LW-1:0]    pool_lit = '0;
    logic [NM*NM-1:0]    sum_pool = '0;
    logic [NM-1:0]       sum_o, pool_o, slow_o;

    int checks = 0;
    int errors = 0;

    pta_array #(.N_IN(NI), .N_MC(NM), .N_PT(NP)) uut (
        .arr_i      (arr),
        .pt_lit_i   (pt_lit),
        .pt_pool_i  (pt_pool),
        .pt_en_i    (pt_en),
        .pool_lit_i (pool_lit),
        .sum_pool_i (sum_pool),
        .sum_o      (sum_o),
        .pool_o     (pool_o),
        .slow_o     (slow_o)
    );

    function automatic logic cond(logic [1:0] c, logic x);
        if (c == 2'b00) return 1'b1;
        if (c == 2'b01) return x;
        if (c == 2'b10) return !x;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [NM-1:0] act, logic [NM-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        @(posedge clk);
        #1;
        arr = '0; pt_lit = '0; pt_pool = '0; pt_en = '0;
        pool_lit = '0; sum_pool = '0;
    endtask

    task automatic model(output logic [NM-1:0] e_sum, output logic [NM-1:0] e_pool,
                         output logic [NM-1:0] e_slow);
        for (int m = 0; m < NM; m++) begin
            logic t;
            t = 1'b1;
            for (int i = 0; i < NI; i++) t = t & cond(pool_lit[m*LW + 2*i +: 2], arr[i]);
            e_pool[m] = !t;
        end
        for (int m = 0; m < NM; m++) begin
            logic s, w;
            s = 1'b0;
            w = 1'b0;
            for (int p = 0; p < NP; p++) begin
                logic t;
                int k;
                k = m*NP + p;
                t = 1'b1;
                for (int i = 0; i < NI; i++) t = t & cond(pt_lit[k*LW + 2*i +: 2], arr[i]);
                for (int e = 0; e < NM; e++) begin
                    if (pt_pool[k*NM + e]) begin
                        t = t & e_pool[e];
                        if (pt_en[k]) w = 1'b1;
                    end
                end
                if (pt_en[k]) s = s | t;
            end
            for (int e = 0; e < NM; e++) begin
                if (sum_pool[m*NM + e]) begin
                    s = s | e_pool[e];
                    w = 1'b1;
                end
            end
            e_sum[m] = s;
            e_slow[m] = w;
        end
    endtask

    function automatic logic [1:0] rand_code();
        int r;
        r = int'($urandom % 20);
        if (r < 2) return 2'b01;
        if (r < 4) return 2'b10;
        if (r == 4) return 2'b11;
        return 2'b00;
    endfunction

    logic finished = 1'b0;

    initial begin
        logic [NM-1:0] es, ep, ew;
        // idle configuration after start-up
        settle();
        check("R3 idle sum", sum_o, '0);
        check("R4 idle pool", pool_o, '0);
        check("R9 idle slow", slow_o, '0);

        // table of single-term literal cases on macrocell 0 term 0
        foreach (TBL[n]) begin
            @(posedge clk);
            #1;
            arr = TBL[n][24:17];
            pt_lit[15:0] = TBL[n][16:1];
            pt_en = '0;
            pt_en[0] = 1'b1;
            settle();
            check("R1 R2 R3 literal table", sum_o, {{(NM-1){1'b0}}, TBL[n][0]});
        end

        // R4: pool term of macrocell 3 needs input0 high
        clear_cfg();
        pool_lit[3*LW +: 2] = 2'b01;
        settle();
        check("R4 pool inverted low input", pool_o, 16'h0008);
        @(posedge clk); #1; arr = 8'h01;
        settle();
        check("R4 pool inverted high input", pool_o, 16'h0000);

        // R6 R7: pool output 3 shared by macrocells 5 and 9
        @(posedge clk); #1;
        arr = 8'h00;
        sum_pool[5*NM + 3] = 1'b1;
        sum_pool[9*NM + 3] = 1'b1;
        settle();
        check("R6 R7 shared direct pool sum", sum_o, 16'h0220);
        check("R9 direct pool slow", slow_o, 16'h0220);

        // R8: term configuration must not disturb the pool
        @(posedge clk); #1;
        pt_en = '1;
        for (int b = 0; b < NM*NP*LW; b++) pt_lit[b] = 1'($urandom % 2);
        for (int b = 0; b < NM*NP*NM; b++) pt_pool[b] = 1'($urandom % 2);
        settle();
        check("R8 pool independent of term config", pool_o, 16'h0008);

        // R5: macrocell 2 term 0 uses pool output 3 only
        clear_cfg();
        pool_lit[3*LW +: 2] = 2'b01;
        pt_en[2*NP + 0] = 1'b1;
        pt_pool[(2*NP + 0)*NM + 3] = 1'b1;
        settle();
        check("R5 pool in term high", sum_o, 16'h0004);
        check("R9 term pool slow", slow_o, 16'h0004);
        @(posedge clk); #1; arr = 8'h01;
        settle();
        check("R5 pool in term low", sum_o, 16'h0000);
        check("R9 slow independent of value", slow_o, 16'h0004);

        // R9 R3: disabled term keeps its pool selection but is ignored
        @(posedge clk); #1; pt_en[2*NP + 0] = 1'b0;
        settle();
        check("R9 disabled term not slow", slow_o, 16'h0000);
        check("R3 disabled term ignored", sum_o, 16'h0000);

        // R5: literal and pool output ANDed in macrocell 2 term 1
        @(posedge clk); #1;
        pt_en[2*NP + 1] = 1'b1;
        pt_lit[(2*NP + 1)*LW + 2 +: 2] = 2'b01;
        pt_pool[(2*NP + 1)*NM + 3] = 1'b1;
        arr = 8'h02;
        settle();
        check("R5 literal and pool both true", sum_o, 16'h0004);
        @(posedge clk); #1; arr = 8'h03;
        settle();
        check("R5 pool false kills term", sum_o, 16'h0000);

        // random sparse masks against the software model
        for (int it = 0; it < 300; it++) begin
            @(posedge clk); #1;
            arr = NI'($urandom);
            for (int k = 0; k < NM*NP; k++) begin
                pt_en[k] = 1'($urandom % 2);
                for (int i = 0; i < NI; i++) pt_lit[k*LW + 2*i +: 2] = rand_code();
            end
            for (int m = 0; m < NM; m++)
                for (int i = 0; i < NI; i++) pool_lit[m*LW + 2*i +: 2] = rand_code();
            for (int b = 0; b < NM*NP*NM; b++) pt_pool[b] = ($urandom % 24 == 0);
            for (int b = 0; b < NM*NM; b++) sum_pool[b] = ($urandom % 24 == 0);
            settle();
            model(es, ep, ew);
            check("R1 R3 R5 R6 random sums", sum_o, es);
            check("R4 random pool", pool_o, ep);
            check("R9 random slow", slow_o, ew);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule